// File: doc/BRIEF.md
# Fixed-Frame Serial Register Slave

This block lets a host read and write a small bank of 12-bit registers over three wires: a serial clock, an active-low select and a data line. The data line is bidirectional at the pad. The block gives its receive side as `sd_in`, and its drive side as `sd_out` plus the enable `sd_oe`. The pad is a true three-state buffer that drives both high and low. All three inputs are brought into the core clock `clk` and oversampled there. Serial clock edges are found from the synchronized samples, so pauses of any length between bytes leave the framing intact.

Every transaction is a fixed-length frame. Its first bit picks the direction: 0 gives a 16-bit write and 1 gives a 24-bit read. The next three bits are a register address, sent MSB first. Only addresses below `NREG` belong to this slave. Frames that name any other address are still counted bit by bit, so the slave stays aligned when other devices share the bus with no idle time between frames. In a read, the slave returns one dead bit and then a 15-bit word made of the address and the register contents.

Top module: `ssr_slave`

## Requirements
- R1: After reset, `sd_oe` and `sd_out` are 0 and every register holds 0.
- R2: Write frame, 16 bits, sampled on rising `sclk` with MSB first: bit 1 = 0, bits 2-4 = address, bits 5-16 = 12-bit value. When the address is below `NREG`, the value is stored at the 16th rising edge.
- R3: Read frame, 24 bits: bit 1 = 1 and bits 2-4 = address. Bits 5-24 from the host are ignored. The register is fetched at the 8th rising edge. The slave drives a dead bit of 0 during bit 9, then {address[2:0], value[11:0]}, MSB first, during bits 10-24.
- R4: `sd_oe` is high only from the falling edge after bit 8 of an accepted read until the falling edge after bit 24. It is low during bits 1-8 of every frame.
- R5: A frame whose address is `NREG` or above changes no register and never raises `sd_oe`, and it still uses its full length.
- R6: Frames may follow each other with no idle clock. Each one is decoded from its own first bit.
- R7: The serial clock may stay high for any time between bytes of a frame without changing the result.
- R8: When `cs_n` goes high in the middle of a frame, the frame is dropped: no register changes, `sd_oe` goes low, and the next frame starts at bit 1.
- R9: `sd_out` changes only in response to a falling edge of `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host; idles high |
| cs_n | input | 1 | Active-low select; high aborts or holds off framing |
| sd_in | input | 1 | Serial data from the pad |
| sd_out | output | 1 | Serial data toward the pad during read-back |
| sd_oe | output | 1 | Pad drive enable; low leaves the line at high impedance |

## Verification
Several rules are checked on every core cycle: a deselected slave releases the line and clears its bit counter, the first driven bit is the dead 0, output data moves only after a detected falling edge, the drive never appears outside a read frame, the counter never passes the read length, and a commit always closes a frame. Other properties depend on whole transactions and are shown only by the bench scenarios. These are the correct stored values, the address echo, that unowned addresses have no effect, alignment across back-to-back mixed traffic with random inter-byte pauses, and recovery after an abort in a write or a read.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 12;
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int CNT_W  = 5;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [WORD_W-1:0] word_t;

  localparam cnt_t WR_LEN   = cnt_t'(16);
  localparam cnt_t RD_LEN   = cnt_t'(24);
  localparam cnt_t ADDR_END = cnt_t'(3);   // count before the 4th bit
  localparam cnt_t FETCH_AT = cnt_t'(7);   // count before the 8th bit
  localparam cnt_t DEAD_AT  = cnt_t'(8);   // count after the 8th bit

  function automatic cnt_t frame_len(input logic is_rd);
    return is_rd ? RD_LEN : WR_LEN;
  endfunction

  function automatic logic addr_owned(input addr_t a, input int nreg);
    return int'(a) < nreg;
  endfunction

  function automatic word_t read_word(input addr_t a, input data_t v);
    return {a, v};
  endfunction

  function automatic logic in_data_phase(input cnt_t c);
    return (c > DEAD_AT) && (c < RD_LEN);
  endfunction
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else if (g == 0) stg[g] <= d;
        else stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ssr_framer.sv
module ssr_framer
  import ssr_pkg::*;
#(
  parameter int NREG = 5
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rise,
  input  logic  cs_act,
  input  logic  din,
  output cnt_t  bit_cnt,
  output logic  rd_flag,
  output addr_t addr,
  output logic  hit,
  output logic  wr_commit,
  output data_t wr_data,
  output logic  rd_fetch,
  output logic  pkt_end,
  output logic  abort_ev
);
  logic [WR_LEN-1:0] sh;
  logic [WR_LEN-1:0] shin;
  cnt_t nxt;
  cnt_t plen;

  assign shin = {sh[WR_LEN-2:0], din};
  assign nxt  = bit_cnt + cnt_t'(1);
  assign plen = frame_len(rd_flag);
  assign hit  = addr_owned(addr, NREG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      sh      <= '0;
      rd_flag <= 1'b0;
      addr    <= '0;
    end else if (!cs_act) begin
      bit_cnt <= '0;
    end else if (rise) begin
      sh <= shin;
      if (bit_cnt == '0) rd_flag <= din;
      if (bit_cnt == ADDR_END) addr <= {sh[1:0], din};
      bit_cnt <= (nxt == plen) ? '0 : nxt;
    end
  end

  assign wr_data   = shin[DATA_W-1:0];
  assign wr_commit = cs_act & rise & !rd_flag & hit & (nxt == WR_LEN);
  assign rd_fetch  = cs_act & rise & rd_flag & hit & (bit_cnt == FETCH_AT);
  assign pkt_end   = cs_act & rise & (nxt == plen);
  assign abort_ev  = !cs_act & (bit_cnt != '0);
endmodule

// File: rtl/ssr_regbank.sv
module ssr_regbank
  import ssr_pkg::*;
#(
  parameter int NREG = 5
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  addr_t addr,
  input  data_t wdata,
  output data_t rdata
);
  data_t regs [NREG];

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[g] <= '0;
        else if (wr_en && int'(addr) == g) regs[g] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (int'(addr) == i) rdata = regs[i];
  end
endmodule

// File: rtl/ssr_readout.sv
module ssr_readout
  import ssr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fall,
  input  logic  cs_act,
  input  logic  load,
  input  word_t load_word,
  input  cnt_t  bit_cnt,
  input  logic  rd_flag,
  input  logic  hit,
  output logic  sd_out,
  output logic  sd_oe
);
  word_t shr;
  logic  rd_ok;

  assign rd_ok = rd_flag & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shr    <= '0;
      sd_out <= 1'b0;
      sd_oe  <= 1'b0;
    end else if (!cs_act) begin
      sd_oe <= 1'b0;
    end else begin
      if (load) shr <= load_word;
      if (fall) begin
        if (rd_ok && bit_cnt == DEAD_AT) begin
          sd_oe  <= 1'b1;
          sd_out <= 1'b0;
        end else if (rd_ok && in_data_phase(bit_cnt)) begin
          sd_oe  <= 1'b1;
          sd_out <= shr[WORD_W-1];
          shr    <= {shr[WORD_W-2:0], 1'b0};
        end else begin
          sd_oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ssr_slave.sv
module ssr_slave
  import ssr_pkg::*;
#(
  parameter int NREG = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sd_in,
  output logic sd_out,
  output logic sd_oe
);
  logic [2:0] pins_s;
  logic sclk_s, cs_act, din_s, sclk_q;
  logic sclk_rise, sclk_fall;
  cnt_t bit_cnt;
  logic rd_flag, hit, wr_commit, rd_fetch, pkt_end, abort_ev;
  addr_t addr;
  data_t wr_data, rd_val;

  ssr_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk, cs_n, sd_in}), .q(pins_s));

  assign sclk_s = pins_s[2];
  assign cs_act = !pins_s[1];
  assign din_s  = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b1;
    else sclk_q <= sclk_s;
  end

  assign sclk_rise = sclk_s & !sclk_q;
  assign sclk_fall = !sclk_s & sclk_q;

  ssr_framer #(.NREG(NREG)) u_framer (
    .clk(clk), .rst_n(rst_n), .rise(sclk_rise), .cs_act(cs_act), .din(din_s),
    .bit_cnt(bit_cnt), .rd_flag(rd_flag), .addr(addr), .hit(hit),
    .wr_commit(wr_commit), .wr_data(wr_data), .rd_fetch(rd_fetch),
    .pkt_end(pkt_end), .abort_ev(abort_ev));

  ssr_regbank #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_commit), .addr(addr),
    .wdata(wr_data), .rdata(rd_val));

  ssr_readout u_out (
    .clk(clk), .rst_n(rst_n), .fall(sclk_fall), .cs_act(cs_act),
    .load(rd_fetch), .load_word(read_word(addr, rd_val)),
    .bit_cnt(bit_cnt), .rd_flag(rd_flag), .hit(hit),
    .sd_out(sd_out), .sd_oe(sd_oe));
endmodule

// File: rtl/ssr_slave_chk.sv
module ssr_slave_chk
  import ssr_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic sclk_fall,
  input logic cs_act,
  input cnt_t bit_cnt,
  input logic rd_flag,
  input logic wr_commit,
  input logic pkt_end,
  input logic sd_out,
  input logic sd_oe
);
  // R8
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sd_oe);
  // R8
  abort_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> bit_cnt == '0);
  // R3
  dead_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_oe) |-> !sd_out);
  // R9
  out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(sd_out));
  // R4
  drive_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> rd_flag);
  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < RD_LEN);
  // R2
  commit_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> pkt_end);
  // R2
  commit_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> bit_cnt == '0);
endmodule

bind ssr_slave ssr_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .cs_act(cs_act),
  .bit_cnt(bit_cnt), .rd_flag(rd_flag), .wr_commit(wr_commit),
  .pkt_end(pkt_end), .sd_out(sd_out), .sd_oe(sd_oe));

// File: tb/ssr_slave_tb.sv
module ssr_slave_tb;
  localparam int NREG = 5;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic cs_n = 1'b1;
  logic sd_in = 1'b0;
  logic sd_out, sd_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [11:0] model [8];

  always #2.5 clk = ~clk;

  ssr_slave #(.NREG(NREG), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit owned(input logic [2:0] a);
    return int'(a) < NREG;
  endfunction

  function automatic logic [14:0] expect_word(input logic [2:0] a);
    return {a, model[a]};
  endfunction

  task automatic xfer_bit(input logic b, output logic so, output logic soe);
    @(negedge clk);
    sclk = 1'b0;
    sd_in = b;
    repeat (H) @(negedge clk);
    so = sd_out;
    soe = sd_oe;
    sclk = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  // Sends nbits of a frame (nbits 0 = full frame); gap = idle cycles between bytes.
  task automatic frame(input bit rd, input logic [2:0] a, input logic [11:0] d,
                       input int gap, input int nbits,
                       output logic [14:0] rb, output bit dead_ok,
                       output bit early_oe, output int oe_cnt);
    logic [23:0] bits;
    int len;
    logic so, soe;
    len = rd ? 24 : 16;
    if (nbits > 0) len = nbits;
    bits = rd ? {1'b1, a, 20'h5a5a5} : {1'b0, a, d, 8'h00};
    rb = '0; dead_ok = 1'b0; early_oe = 1'b0; oe_cnt = 0;
    for (int i = 0; i < len; i++) begin
      if ((i == 8 || i == 16) && gap > 0) repeat (gap) @(negedge clk);
      xfer_bit(bits[23-i], so, soe);
      if (soe) oe_cnt++;
      if (i < 8 && soe) early_oe = 1'b1;
      if (i == 8) dead_ok = soe && (so == 1'b0);
      if (i >= 9) rb = {rb[13:0], so};
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [11:0] d, input int gap);
    logic [14:0] rb; bit dk, eo; int oc;
    frame(1'b0, a, d, gap, 0, rb, dk, eo, oc);
    chk(!eo && oc == 0, owned(a) ? "R2" : "R5", "write frame drove line", oc, 0);
    if (owned(a)) model[a] = d;
  endtask

  task automatic do_read(input logic [2:0] a, input int gap, input string req);
    logic [14:0] rb; bit dk, eo; int oc;
    frame(1'b1, a, 12'h0, gap, 0, rb, dk, eo, oc);
    chk(!eo, "R4", "drive during bits 1-8", int'(eo), 0);
    if (owned(a)) begin
      chk(dk, "R3", "dead bit", int'(dk), 1);
      chk(oc == 16, "R4", "driven bit count", oc, 16);
      chk(rb == expect_word(a), req, "read word", int'(rb), int'(expect_word(a)));
    end else begin
      chk(oc == 0, "R5", "unowned read drove line", oc, 0);
    end
  endtask

  task automatic abort_after(input int n);
    @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(sd_oe == 1'b0, "R8", "oe after abort", int'(sd_oe), 0);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    if (n < 0) chk(1'b0, "R8", "bad abort arg", n, 0);
  endtask

  initial begin
    logic [14:0] rb; bit dk, eo; int oc;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (5) @(negedge clk);
    chk(sd_oe == 1'b0 && sd_out == 1'b0, "R1", "outputs in reset",
        int'({sd_oe, sd_out}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: all registers read back zero
    for (int a = 0; a < NREG; a++) do_read(3'(a), 0, "R1");
    // R2 directed, extremes of the value
    do_write(3'd0, 12'hfff, 0);
    do_write(3'd4, 12'h801, 0);
    do_read(3'd0, 0, "R2");
    do_read(3'd4, 0, "R3");
    // R5: unowned addresses change nothing and keep alignment (R6)
    do_write(3'd5, 12'h123, 0);
    do_write(3'd7, 12'h456, 0);
    do_read(3'd6, 0, "R5");
    do_read(3'd4, 0, "R6");
    // R7: long pauses between bytes
    do_write(3'd2, 12'h3c5, 40);
    do_read(3'd2, 55, "R7");
    // R8: abort in the middle of a write, then next frame starts clean
    frame(1'b0, 3'd2, 12'h0aa, 0, 15, rb, dk, eo, oc);
    abort_after(15);
    do_read(3'd2, 0, "R8");
    // R8: abort during read-back
    frame(1'b1, 3'd2, 12'h0, 0, 14, rb, dk, eo, oc);
    chk(oc > 0, "R8", "read started driving", oc, 5);
    abort_after(14);
    do_write(3'd1, 12'h777, 0);
    do_read(3'd1, 0, "R8");
    // R6: back-to-back constrained random mix
    for (int k = 0; k < 70; k++) begin
      logic [2:0] a;
      int gap;
      a = 3'($urandom_range(0, 7));
      gap = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 20) : 0;
      if ($urandom_range(0, 1) == 1) do_read(a, gap, "R6");
      else do_write(a, 12'($urandom), gap);
    end
    for (int a = 0; a < 8; a++) do_read(3'(a), 0, "R3");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule